// File: doc/BRIEF.md
# Virtual Interrupt Maintenance Signal Generator

This block holds the 32-bit hypervisor control word for one virtual CPU interface. It keeps a 5-bit count of deactivations that found no matching list entry. From that count, the list-entry occupancy, the list-entry pending state and the two virtual group enables, it produces a single level-sensitive maintenance interrupt. Software writes the control word through a simple write port and reads it back on a continuous readback bus.

A small two-state machine owns the maintenance output.

- **States:** `MI_QUIET` (output low) and `MI_RAISED` (output high).
- **`MI_QUIET` → `MI_RAISED`** (*raise*): taken at a clock edge when the interface enable is set and any enabled condition holds.
- **`MI_RAISED` → `MI_QUIET`** (*drop*): taken at a clock edge when the enable is clear or no enabled condition holds.
- **Self-loops:** *hold-quiet* and *hold-raised* are the two remaining cases.

The output therefore follows its inputs one cycle later.

Top module: `vmaint_gen`

## Requirements
- R1: After reset the readback value is all zeros and the maintenance output is low.
- R2: A write stores bits 31:27, 14:10 and 8:0 of the write data. Bits 26:15 and bit 9 always read as zero.
- R3: A no-match deactivation pulse increments the count in bits 31:27 by one, modulo 32 (31 wraps to 0). This applies when the pulse is not flagged as a virtual SGI, or when bit 8 is clear.
- R4: When bit 8 is set, a no-match deactivation flagged as a virtual SGI leaves the count unchanged.
- R5: A write in the same cycle as a counting deactivation wins: the count takes the written value.
- R6: With bit 2 set, the maintenance output is high while the count is nonzero.
- R7: With bit 3 set, the maintenance output is high while no list entry has state 2'b01. Entry i's state is `lr_state[2i+1:2i]`.
- R8: With bit 1 set, the maintenance output is high while zero or one bits of `lr_valid` are set.
- R9: Each of bits 4, 5, 6 and 7 adds one condition to the maintenance output:
  - bit 4: group 0 enabled;
  - bit 5: group 0 disabled;
  - bit 6: group 1 enabled;
  - bit 7: group 1 disabled.
- R10: While bit 0 is clear, the maintenance output is low whatever the other bits and inputs are. The count still updates.
- R11: The maintenance output is registered. It reflects the control word and inputs present at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word readback |
| lr_state | input | 2*NUM_LR | Per-entry state, 2 bits per entry |
| lr_valid | input | NUM_LR | Per-entry valid flags |
| grp0_en | input | 1 | Virtual group 0 enable |
| grp1_en | input | 1 | Virtual group 1 enable |
| nomatch_deact | input | 1 | One-cycle pulse: deactivation with no matching entry |
| deact_is_vsgi | input | 1 | Qualifies the pulse as a virtual SGI deactivation |
| maint_irq | output | 1 | Level maintenance interrupt |

## Verification
The assertions take for granted that the deactivation flag only matters in cycles where the pulse is high. They also assume the write strobe and its data are valid together on one edge. The properties never depend on the list vectors being held steady between edges.

The stimulus drives every input on the falling edge and keeps each value for a whole cycle. Pulses last exactly one cycle. A running model in the bench predicts the readback value and the maintenance output after each rising edge.

// File: rtl/vmaint_pkg.sv
package vmaint_pkg;
    localparam int HCR_W      = 32;
    localparam int CNT_W      = 5;
    localparam int CNT_LSB    = 27;
    localparam int B_EN       = 0;
    localparam int B_UNDER    = 1;
    localparam int B_CNTIE    = 2;
    localparam int B_NOPEND   = 3;
    localparam int B_G0ON     = 4;
    localparam int B_G0OFF    = 5;
    localparam int B_G1ON     = 6;
    localparam int B_G1OFF    = 7;
    localparam int B_SGIMUTE  = 8;
    localparam logic [HCR_W-1:0] WRITE_MASK = 32'hF800_7DFF;
    localparam logic [1:0] ST_PENDING = 2'b01;

    typedef enum logic {
        MI_QUIET  = 1'b0,
        MI_RAISED = 1'b1
    } mi_state_t;
endpackage

// File: rtl/hcr_ctrl_reg.sv
module hcr_ctrl_reg
    import vmaint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [HCR_W-1:0] wr_data,
    input  logic             deact_pulse,
    input  logic             deact_vsgi,
    output logic [HCR_W-1:0] ctrl_q
);
    logic [HCR_W-1:0] word_q;
    logic             bump;

    assign bump   = deact_pulse && !(deact_vsgi && word_q[B_SGIMUTE]);
    assign ctrl_q = word_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_en) begin
            word_q <= wr_data & WRITE_MASK;
        end else if (bump) begin
            word_q[CNT_LSB +: CNT_W] <= word_q[CNT_LSB +: CNT_W] + 1'b1;
        end
    end

    // R2 R5
    wr_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (ctrl_q == ($past(wr_data) & WRITE_MASK)));

    // R3
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deact_pulse && !deact_vsgi && !wr_en) |=>
        (ctrl_q[CNT_LSB +: CNT_W] == $past(ctrl_q[CNT_LSB +: CNT_W]) + 5'd1));

    // R4
    vsgi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (deact_pulse && deact_vsgi && ctrl_q[B_SGIMUTE] && !wr_en) |=>
        $stable(ctrl_q));
endmodule

// File: rtl/lr_scan.sv
module lr_scan #(
    parameter int NUM_LR = 4
) (
    input  logic [2*NUM_LR-1:0] lr_state,
    input  logic [NUM_LR-1:0]   lr_valid,
    output logic                any_pending,
    output logic                few_valid
);
    import vmaint_pkg::*;

    logic [NUM_LR-1:0] pend_vec;
    logic [NUM_LR:0]   seen_one;
    logic [NUM_LR:0]   seen_two;

    assign seen_one[0] = 1'b0;
    assign seen_two[0] = 1'b0;

    for (genvar i = 0; i < NUM_LR; i++) begin : g_entry
        assign pend_vec[i]   = (lr_state[2*i +: 2] == ST_PENDING);
        assign seen_two[i+1] = seen_two[i] | (seen_one[i] & lr_valid[i]);
        assign seen_one[i+1] = seen_one[i] | lr_valid[i];
    end

    assign any_pending = |pend_vec;
    assign few_valid   = !seen_two[NUM_LR];
endmodule

// File: rtl/maint_fsm.sv
module maint_fsm
    import vmaint_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [HCR_W-1:0] ctrl_q,
    input  logic             any_pending,
    input  logic             few_valid,
    input  logic             grp0_en,
    input  logic             grp1_en,
    output logic             maint_irq
);
    mi_state_t state_q, state_d;
    logic      cond_any;

    always_comb begin
        cond_any = (ctrl_q[B_CNTIE]  && (ctrl_q[CNT_LSB +: CNT_W] != '0))
                 | (ctrl_q[B_NOPEND] && !any_pending)
                 | (ctrl_q[B_UNDER]  && few_valid)
                 | (ctrl_q[B_G0ON]   && grp0_en)
                 | (ctrl_q[B_G0OFF]  && !grp0_en)
                 | (ctrl_q[B_G1ON]   && grp1_en)
                 | (ctrl_q[B_G1OFF]  && !grp1_en);
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MI_QUIET:  if (ctrl_q[B_EN] && cond_any)    state_d = MI_RAISED;
            MI_RAISED: if (!ctrl_q[B_EN] || !cond_any)  state_d = MI_QUIET;
            default:   state_d = MI_QUIET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MI_QUIET;
        else        state_q <= state_d;
    end

    always_comb begin
        maint_irq = (state_q == MI_RAISED);
    end

    // R10
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_q[B_EN] |=> !maint_irq);

    // R7
    nopend_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[B_EN] && ctrl_q[B_NOPEND] && !any_pending) |=> maint_irq);

    // R8
    under_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q[B_EN] && ctrl_q[B_UNDER] && few_valid) |=> maint_irq);
endmodule

// File: rtl/vmaint_gen.sv
module vmaint_gen
    import vmaint_pkg::*;
#(
    parameter int NUM_LR = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [31:0]         wr_data,
    output logic [31:0]         rd_data,
    input  logic [2*NUM_LR-1:0] lr_state,
    input  logic [NUM_LR-1:0]   lr_valid,
    input  logic                grp0_en,
    input  logic                grp1_en,
    input  logic                nomatch_deact,
    input  logic                deact_is_vsgi,
    output logic                maint_irq
);
    logic [HCR_W-1:0] ctrl_q;
    logic             any_pending;
    logic             few_valid;

    hcr_ctrl_reg u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_data     (wr_data),
        .deact_pulse (nomatch_deact),
        .deact_vsgi  (deact_is_vsgi),
        .ctrl_q      (ctrl_q)
    );

    lr_scan #(.NUM_LR(NUM_LR)) u_scan (
        .lr_state    (lr_state),
        .lr_valid    (lr_valid),
        .any_pending (any_pending),
        .few_valid   (few_valid)
    );

    maint_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .ctrl_q      (ctrl_q),
        .any_pending (any_pending),
        .few_valid   (few_valid),
        .grp0_en     (grp0_en),
        .grp1_en     (grp1_en),
        .maint_irq   (maint_irq)
    );

    assign rd_data = ctrl_q;

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> (rd_data == '0 && !maint_irq));
endmodule

// File: tb/vmaint_gen_bench.sv
module vmaint_gen_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NLR = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic [31:0]      wr_data = '0;
    logic [31:0]      rd_data;
    logic [2*NLR-1:0] lr_state = '0;
    logic [NLR-1:0]   lr_valid = '0;
    logic             grp0_en = 1'b0;
    logic             grp1_en = 1'b0;
    logic             nomatch_deact = 1'b0;
    logic             deact_is_vsgi = 1'b0;
    logic             maint_irq;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    logic [31:0] m_reg = '0;
    bit          m_irq = 0;

    vmaint_gen #(.NUM_LR(NLR)) u_vmaint_gen (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .lr_state(lr_state), .lr_valid(lr_valid),
        .grp0_en(grp0_en), .grp1_en(grp1_en), .nomatch_deact(nomatch_deact),
        .deact_is_vsgi(deact_is_vsgi), .maint_irq(maint_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic bit model_cond(logic [31:0] w);
        int nv = 0;
        bit pend = 0;
        int cnt = int'(w[31:27]);
        bit c;
        for (int i = 0; i < NLR; i++) begin
            if (lr_valid[i]) nv++;
            if (lr_state[2*i +: 2] == 2'b01) pend = 1;
        end
        c = (w[2] && cnt != 0) || (w[3] && !pend) || (w[1] && nv <= 1)
         || (w[4] && grp0_en) || (w[5] && !grp0_en)
         || (w[6] && grp1_en) || (w[7] && !grp1_en);
        return w[0] && c;
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic tick(string tag);
        bit nxt_irq;
        int cnt;
        @(posedge clk);
        @(negedge clk);
        nxt_irq = model_cond(m_reg);
        if (wr_en) begin
            m_reg = 0;
            for (int b = 0; b < 32; b++)
                if ((b >= 27) || (b >= 10 && b <= 14) || (b <= 8)) m_reg[b] = wr_data[b];
        end else if (nomatch_deact && !(deact_is_vsgi && m_reg[8])) begin
            cnt = (int'(m_reg[31:27]) + 1) % 32;
            m_reg[31:27] = cnt[4:0];
        end
        m_irq = nxt_irq;
        check(tag, rd_data, m_reg, "rd_data");
        check(tag, {31'b0, maint_irq}, {31'b0, m_irq}, "maint_irq");
        wr_en = 0;
        nomatch_deact = 0;
        deact_is_vsgi = 0;
    endtask

    task automatic wr(logic [31:0] v, string tag);
        wr_en = 1;
        wr_data = v;
        tick(tag);
    endtask

    task automatic pulse(bit vsgi, string tag);
        nomatch_deact = 1;
        deact_is_vsgi = vsgi;
        tick(tag);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        lr_state = {NLR{2'b01}};
        lr_valid = '1;
        repeat (2) @(negedge clk);
        // R1: reset state
        check("R1", rd_data, 32'h0, "rd_data");
        check("R1", {31'b0, maint_irq}, 32'h0, "maint_irq");
        rst_n = 1;
        tick("R1");

        // R2: writable and reserved bits
        wr(32'hFFFF_FFFF, "R2");
        tick("R2");
        wr(32'h0000_0000, "R2");
        wr(32'h0400_8200, "R2");

        // R6 with R3 counting
        wr(32'h0000_0005, "R6");
        tick("R6");
        pulse(0, "R3");
        tick("R6");
        for (int k = 0; k < 31; k++) pulse(0, "R3");
        tick("R3");

        // R4: muted virtual SGI deactivations
        wr(32'h0000_0105, "R4");
        pulse(1, "R4");
        pulse(1, "R4");
        tick("R4");
        pulse(0, "R3");
        wr(32'h0000_0005, "R3");
        pulse(1, "R3");
        tick("R3");

        // R5: write beats a same-cycle increment
        nomatch_deact = 1;
        wr(32'h2800_0005, "R5");
        tick("R5");

        // R7: no pending entry
        wr(32'h0000_0009, "R7");
        tick("R7");
        lr_state = 8'b10_11_00_00;
        tick("R7");
        tick("R7");
        lr_state = 8'b10_01_00_00;
        tick("R7");
        tick("R7");

        // R8: at most one valid entry
        wr(32'h0000_0003, "R8");
        foreach (lr_valid[i]) begin end
        lr_valid = 4'b0000; tick("R8"); tick("R8");
        lr_valid = 4'b0100; tick("R8"); tick("R8");
        lr_valid = 4'b0110; tick("R8"); tick("R8");
        lr_valid = 4'b1001; tick("R8"); tick("R8");

        // R9: group enable conditions
        for (int b = 4; b <= 7; b++) begin
            wr(32'h1 | (32'h1 << b), "R9");
            for (int g = 0; g < 4; g++) begin
                grp0_en = g[0];
                grp1_en = g[1];
                tick("R9");
                tick("R9");
            end
        end

        // R11: one-cycle latency on enable change
        wr(32'h0000_0011, "R11");
        grp0_en = 1;
        tick("R11");
        grp0_en = 0;
        tick("R11");
        tick("R11");

        // R10: global enable clear masks everything
        lr_valid = '0;
        lr_state = '0;
        wr(32'h0000_01FE, "R10");
        tick("R10");
        pulse(0, "R10");
        tick("R10");
        wr(32'h0000_01FF, "R10");
        tick("R10");
        wr(32'h0000_01FE, "R10");
        tick("R10");

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule